// File: doc/BRIEF.md
# Temperature Threshold Alert Comparator

This block watches a stream of signed 16-bit temperature results and compares each one against a programmable high limit and a programmable low limit. A conversion engine supplies a result word and a one-cycle strobe when a conversion ends. The register file supplies both limits, a mode bit and a polarity bit. The bus side supplies two more strobes: one when the configuration register is read, and one when an SMBus alert-response command is answered. The block returns a HIGH status flag, a LOW status flag and the level for the alert pin.

The block has two modes. In therm mode it acts as a high-threshold detector with hysteresis. The HIGH flag sets above the high limit and clears only below the low limit. Bus activity cannot clear it, and the alert pin follows it. In alert mode each flag latches when its limit is crossed and stays set until the configuration register is read. An alert response releases the pin but leaves the flags in place. A new mode bit is adopted only at the next conversion end.

Top module: `thr_alert_top`

## Requirements
- R1: Every comparison treats the result and both limits as signed two's-complement 16-bit values.
- R2: In therm mode, a conversion end whose result is strictly greater than the high limit sets the HIGH flag. A result equal to the limit does not set it.
- R3: In therm mode, a set HIGH flag stays set through conversions at or above the low limit. It clears at the first conversion end whose result is strictly below the low limit.
- R4: In therm mode the LOW flag is always 0.
- R5: In therm mode, the configuration-read strobe and the alert-response strobe change neither the flags nor the alert pin. The flags change only at conversion ends.
- R6: In therm mode the alert pin is active exactly while the HIGH flag is set.
- R7: With the polarity bit at 1 the active alert level is 1. With it at 0 the active level is 0. This applies in both modes and takes effect immediately.
- R8: In alert mode, a result strictly above the high limit latches the HIGH flag, and a result strictly below the low limit latches the LOW flag. Either event makes the alert pin active. Later in-range conversions leave the latched flags and the pin unchanged.
- R9: In alert mode, the configuration-read strobe clears both flags and makes the alert pin inactive. If a conversion end falls in the same cycle, that conversion's own crossings are still latched.
- R10: In alert mode, the alert-response strobe makes the alert pin inactive and keeps both flags.
- R11: After reset both flags are 0, the block is in alert mode, and the alert pin is at its inactive level.
- R12: A change of the mode bit is adopted at the next conversion end. At that conversion both flags are cleared first, and then the conversion is evaluated under the new mode's rules. Before that conversion end, the old mode's rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| result | input | 16 | Signed temperature result |
| lim_hi | input | 16 | Signed high limit |
| lim_lo | input | 16 | Signed low limit |
| therm_mode | input | 1 | 1 selects therm mode, 0 selects alert mode |
| alert_pol | input | 1 | 1 makes the active alert level high, 0 makes it low |
| cfg_rd | input | 1 | Configuration-register read strobe |
| ara_ack | input | 1 | SMBus alert-response strobe |
| flag_hi | output | 1 | HIGH status flag |
| flag_lo | output | 1 | LOW status flag |
| alert_o | output | 1 | Alert pin level |

## Verification
The bench drives results exactly equal to each limit. A design that compares with >= or <= would set a flag, or clear the hysteresis, one step too early. It places limits where signed and unsigned ordering disagree, so an unsigned comparator misses the crossing. It pulses the read and alert-response strobes in therm mode and expects no change, and it checks that a read coinciding with a conversion still latches that conversion's crossing. It flips the mode bit between conversions, so a design that adopts the bit at once, or keeps stale flags across the switch, reports wrong flags.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int TEMP_W = 16;

  typedef struct packed {
    logic above;  // result strictly greater than high limit
    logic below;  // result strictly less than low limit
  } thr_cmp_t;
endpackage

// File: rtl/thr_cmp.sv
module thr_cmp
  import thr_pkg::*;
#(
  parameter int W = TEMP_W
) (
  input  logic [W-1:0] result,
  input  logic [W-1:0] lim_hi,
  input  logic [W-1:0] lim_lo,
  output thr_cmp_t     cmp
);
  always_comb begin
    cmp.above = $signed(result) > $signed(lim_hi);
    cmp.below = $signed(result) < $signed(lim_lo);
  end
endmodule

// File: rtl/thr_flag_core.sv
module thr_flag_core
  import thr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     conv_done,
  input  thr_cmp_t cmp,
  input  logic     therm_mode,
  input  logic     cfg_rd,
  input  logic     ara_ack,
  output logic     flag_hi,
  output logic     flag_lo,
  output logic     alert_act,
  output logic     mode_q
);
  logic hi_q, lo_q, act_q;
  logic hi_n, lo_n, act_n, mode_n;
  logic en, mode_chg;
  logic base_hi, base_lo, base_act;

  assign en       = conv_done | cfg_rd | ara_ack;
  assign mode_chg = conv_done & (therm_mode != mode_q);

  // next-state
  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    act_n  = act_q;
    mode_n = mode_q;
    // state a conversion starts from; a mode switch discards old flags
    base_hi  = mode_chg ? 1'b0 : hi_q;
    base_lo  = mode_chg ? 1'b0 : lo_q;
    base_act = mode_chg ? 1'b0 : act_q;
    if (conv_done) begin
      mode_n = therm_mode;
      if (therm_mode) begin
        hi_n  = base_hi ? ~cmp.below : cmp.above;
        lo_n  = 1'b0;
        act_n = hi_n;
      end else begin
        if (cfg_rd) begin
          base_hi  = 1'b0;
          base_lo  = 1'b0;
          base_act = 1'b0;
        end
        if (ara_ack) begin
          base_act = 1'b0;
        end
        hi_n  = base_hi | cmp.above;
        lo_n  = base_lo | cmp.below;
        act_n = base_act | cmp.above | cmp.below;
      end
    end else if (!mode_q) begin
      if (cfg_rd) begin
        hi_n  = 1'b0;
        lo_n  = 1'b0;
        act_n = 1'b0;
      end else if (ara_ack) begin
        act_n = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      act_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (en) begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      act_q  <= act_n;
      mode_q <= mode_n;
    end
  end

  assign flag_hi   = hi_q;
  assign flag_lo   = lo_q;
  assign alert_act = act_q;
endmodule

// File: rtl/thr_pin_drv.sv
module thr_pin_drv (
  input  logic alert_act,
  input  logic alert_pol,
  output logic alert_o
);
  // pol=1: active high, pol=0: active low
  assign alert_o = alert_pol ? alert_act : ~alert_act;
endmodule

// File: rtl/thr_alert_top.sv
module thr_alert_top
  import thr_pkg::*;
#(
  parameter int W = TEMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_done,
  input  logic [W-1:0] result,
  input  logic [W-1:0] lim_hi,
  input  logic [W-1:0] lim_lo,
  input  logic         therm_mode,
  input  logic         alert_pol,
  input  logic         cfg_rd,
  input  logic         ara_ack,
  output logic         flag_hi,
  output logic         flag_lo,
  output logic         alert_o
);
  thr_cmp_t cmp;
  logic     alert_act;
  logic     mode_q;

  thr_cmp #(.W(W)) u_cmp (
    .result (result),
    .lim_hi (lim_hi),
    .lim_lo (lim_lo),
    .cmp    (cmp)
  );

  thr_flag_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .cmp        (cmp),
    .therm_mode (therm_mode),
    .cfg_rd     (cfg_rd),
    .ara_ack    (ara_ack),
    .flag_hi    (flag_hi),
    .flag_lo    (flag_lo),
    .alert_act  (alert_act),
    .mode_q     (mode_q)
  );

  thr_pin_drv u_pin (
    .alert_act (alert_act),
    .alert_pol (alert_pol),
    .alert_o   (alert_o)
  );
endmodule

// File: rtl/thr_alert_chk.sv
module thr_alert_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         conv_done,
  input logic [W-1:0] result,
  input logic [W-1:0] lim_hi,
  input logic [W-1:0] lim_lo,
  input logic         therm_mode,
  input logic         alert_pol,
  input logic         cfg_rd,
  input logic         ara_ack,
  input logic         flag_hi,
  input logic         flag_lo,
  input logic         alert_o,
  input logic         mode_q
);
  p_lo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !flag_lo);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !conv_done) |=> ($stable(flag_hi) && $stable(alert_o) || $changed(alert_pol)));

  p_pin_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (alert_o == (alert_pol ? flag_hi : !flag_hi)));

  p_set_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ($signed(result) > $signed(lim_hi)) &&
     ($signed(lim_lo) <= $signed(lim_hi))) |=> flag_hi);

  p_set_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !therm_mode && ($signed(result) < $signed(lim_lo))) |=> flag_lo);

  p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && cfg_rd && !conv_done) |=> (!flag_hi && !flag_lo));

  p_ara_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && ara_ack && !cfg_rd && !conv_done) |=> ($stable(flag_hi) && $stable(flag_lo)));
endmodule

bind thr_alert_top thr_alert_chk #(.W(W)) u_thr_alert_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .conv_done  (conv_done),
  .result     (result),
  .lim_hi     (lim_hi),
  .lim_lo     (lim_lo),
  .therm_mode (therm_mode),
  .alert_pol  (alert_pol),
  .cfg_rd     (cfg_rd),
  .ara_ack    (ara_ack),
  .flag_hi    (flag_hi),
  .flag_lo    (flag_lo),
  .alert_o    (alert_o),
  .mode_q     (mode_q)
);

// File: tb/thr_alert_top_bench.sv
module thr_alert_top_bench;
  logic        clk;
  logic        rst_n;
  logic        conv_done;
  logic [15:0] result;
  logic [15:0] lim_hi;
  logic [15:0] lim_lo;
  logic        therm_mode;
  logic        alert_pol;
  logic        cfg_rd;
  logic        ara_ack;
  logic        flag_hi;
  logic        flag_lo;
  logic        alert_o;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  thr_alert_top u_thr_alert_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_done  (conv_done),
    .result     (result),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .therm_mode (therm_mode),
    .alert_pol  (alert_pol),
    .cfg_rd     (cfg_rd),
    .ara_ack    (ara_ack),
    .flag_hi    (flag_hi),
    .flag_lo    (flag_lo),
    .alert_o    (alert_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one conversion end; outputs are sampled at the following negedge
  task automatic conv(input logic [15:0] val, input logic rd = 1'b0);
    @(negedge clk);
    result    = val;
    conv_done = 1'b1;
    cfg_rd    = rd;
    @(negedge clk);
    conv_done = 1'b0;
    cfg_rd    = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk);
    cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic pulse_ara();
    @(negedge clk);
    ara_ack = 1'b1;
    @(negedge clk);
    ara_ack = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 hi after reset", flag_hi, 1'b0);
    chk("R11 lo after reset", flag_lo, 1'b0);
    chk("R11 pin inactive pol1", alert_o, 1'b0);
    alert_pol = 1'b0;
    #1;
    chk("R7 R11 pin inactive pol0", alert_o, 1'b1);
    alert_pol = 1'b1;
  endtask

  task automatic t_therm();
    therm_mode = 1'b1;
    lim_hi = 16'd100;
    lim_lo = 16'd50;
    conv(16'd80);
    chk("R2 below high", flag_hi, 1'b0);
    conv(16'd100);
    chk("R2 equal high no set", flag_hi, 1'b0);
    conv(16'd101);
    chk("R2 above high sets", flag_hi, 1'b1);
    chk("R6 pin active", alert_o, 1'b1);
    conv(16'd60);
    chk("R3 hysteresis hold", flag_hi, 1'b1);
    conv(16'd50);
    chk("R3 equal low keeps", flag_hi, 1'b1);
    pulse_rd();
    chk("R5 read keeps hi", flag_hi, 1'b1);
    chk("R5 read keeps pin", alert_o, 1'b1);
    pulse_ara();
    chk("R5 ara keeps pin", alert_o, 1'b1);
    chk("R4 lo zero", flag_lo, 1'b0);
    conv(16'd49);
    chk("R3 below low clears", flag_hi, 1'b0);
    chk("R6 pin released", alert_o, 1'b0);
    conv(16'hFF38);  // -200
    chk("R4 lo zero below limit", flag_lo, 1'b0);
  endtask

  task automatic t_signed();
    therm_mode = 1'b1;
    lim_hi = 16'hFFF6;  // -10
    lim_lo = 16'hFFEC;  // -20
    conv(16'd5);
    chk("R1 signed above", flag_hi, 1'b1);
    conv(16'hFFE2);     // -30
    chk("R1 signed below low clears", flag_hi, 1'b0);
  endtask

  task automatic t_alert();
    therm_mode = 1'b0;
    lim_hi = 16'd100;
    lim_lo = 16'd50;
    conv(16'd70);
    chk("R12 switch clears hi", flag_hi, 1'b0);
    conv(16'd120);
    chk("R8 hi latched", flag_hi, 1'b1);
    chk("R8 lo clear", flag_lo, 1'b0);
    chk("R8 pin active", alert_o, 1'b1);
    conv(16'd70);
    chk("R8 hi stays", flag_hi, 1'b1);
    pulse_ara();
    chk("R10 pin released", alert_o, 1'b0);
    chk("R10 hi kept", flag_hi, 1'b1);
    pulse_rd();
    chk("R9 hi cleared", flag_hi, 1'b0);
    chk("R9 lo cleared", flag_lo, 1'b0);
    conv(16'd10);
    chk("R8 lo latched", flag_lo, 1'b1);
    chk("R8 lo pin active", alert_o, 1'b1);
    alert_pol = 1'b0;
    #1;
    chk("R7 active low", alert_o, 1'b0);
    alert_pol = 1'b1;
    #1;
    chk("R7 active high", alert_o, 1'b1);
    conv(16'd20, 1'b1);
    chk("R9 coincident conv latched", flag_lo, 1'b1);
    pulse_rd();
    chk("R9 read clears lo", flag_lo, 1'b0);
    chk("R9 read clears pin", alert_o, 1'b0);
  endtask

  task automatic t_mode();
    therm_mode = 1'b0;
    lim_hi = 16'd100;
    lim_lo = 16'd50;
    conv(16'd10);
    chk("R12 setup lo", flag_lo, 1'b1);
    therm_mode = 1'b1;
    @(negedge clk);
    chk("R12 no change before conv", flag_lo, 1'b1);
    pulse_rd();
    chk("R12 old mode read clears", flag_lo, 1'b0);
    conv(16'd10);
    chk("R12 therm adopted lo zero", flag_lo, 1'b0);
    conv(16'd120);
    chk("R12 therm hi set", flag_hi, 1'b1);
    therm_mode = 1'b0;
    conv(16'd70);
    chk("R12 switch to alert clears hi", flag_hi, 1'b0);
    chk("R12 switch to alert pin", alert_o, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    conv_done = 1'b0;
    result = '0;
    lim_hi = '0;
    lim_lo = '0;
    therm_mode = 1'b0;
    alert_pol = 1'b1;
    cfg_rd = 1'b0;
    ara_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_therm();
    t_signed();
    t_alert();
    t_mode();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule